// File: doc/BRIEF.md
# Interrupt-Paced I2C Master Controller

This block is an I2C master that software drives through five byte-wide registers on a simple write-strobe bus. Reads are combinational. The block pulls the open-drain SCL and SDA wires low through two drive-enable outputs and reads the SDA wire back. A bit engine, timed by a quarter-bit prescaler, produces the START condition, an address byte taken from the data register, data bytes with their acknowledge slot, and the STOP condition.

Software handles one byte per interrupt. When a byte ends, the engine parks with SCL held low, and the interrupt-pending flag is set if interrupts are enabled. Writing a zero to that flag lets the next byte run. In master transmit mode that byte is the contents of the data register. In master receive mode the received byte is placed in the data register. A START is launched by writing the busy bit of the status register. Clearing busy requests a STOP. Clearing the output-enable bit abandons the bus at once. The line-control register is stored only.

Top module: `i2c_mstr_ctrl`

## Requirements
- R1: After reset, control (0x00), status (0x04) and line control (0x10) read 0x00, and own address (0x08) and data (0x0C) read 0xFF. The interrupt is low and both lines are released.
- R2: The line-control register stores and returns any written byte. A read of an offset at or above 0x14 returns 0x00.
- R3: The own-address register accepts writes only while status bit 4 (output enable) is 0. The data register accepts writes only while that bit is 1.
- R4: Control bit 4 is the pending flag, and the irq output follows it. Writing 0 to the flag clears it. Writing 1 never sets it. It rises only when a byte ends, and only if control bit 5 (interrupt enable) is 1.
- R5: A status write with bit 7 = 1 (master), bit 4 = 1 and bit 5 = 1 on an idle bus sets busy (bit 5). It issues a START, then sends the data register MSB first as the address byte, with bit 0 as the read/write direction.
- R6: Status bit 0 is cleared at START. It is set at the end of a byte when the acknowledge slot was sampled high and control bit 7 (acknowledge enable) is 1. It stays 0 when control bit 7 is 0.
- R7: Clearing the pending flag while busy, with interrupts enabled and the bus parked, runs the next byte. In mode 3 (status bits [7:6] = 11, transmit) that byte is the data register.
- R8: In mode 2 (bits [7:6] = 10, receive), each resumed byte is shifted in MSB first and stored in the data register. The master drives ACK in slot 9 when control bit 7 is 1, and leaves SDA high (NACK) when it is 0.
- R9: A status write with bit 7 = 1, bit 4 = 1 and bit 5 = 0 while the bus is parked issues a STOP and releases both lines. Busy stays set if the pending flag was set at that write. A later pending clear then clears busy without running a byte.
- R10: A status write with bit 4 = 0 clears busy and the pending flag, drops irq and releases both lines within one cycle.
- R11: Within a data or address bit, SDA changes only while SCL is low. After each byte SCL stays low until software resumes or stops.
- R12: Clearing the pending flag with control bit 5 written 0 clears busy and does not resume the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| irq | output | 1 | Level interrupt, equal to the pending flag |
| scl_low | output | 1 | 1 pulls the SCL wire low |
| sda_low | output | 1 | 1 pulls the SDA wire low |
| sda_in | input | 1 | Sensed level of the SDA wire |

## Verification
Register effects are due on the first clock edge after the write strobe. The bench drives each write for one cycle on a falling edge and reads back on the next falling edge. Bus results are due a whole number of quarter-bit periods later, and the prescaler phase is not fixed: a START plus a byte takes 39 quarters and a plain byte takes 36. The bench therefore polls irq with a generous bound and never samples at a fixed edge for these. STOP completion and the absence of a resumed byte are checked after a fixed wait longer than three quarters. A behavioural target on the wired-AND lines checks what crossed the bus.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int REG_AW = 5;
  localparam logic [REG_AW-1:0] OFS_CTRL = 5'h00;
  localparam logic [REG_AW-1:0] OFS_STAT = 5'h04;
  localparam logic [REG_AW-1:0] OFS_OWN  = 5'h08;
  localparam logic [REG_AW-1:0] OFS_DATA = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_LINE = 5'h10;

  localparam logic [1:0] MODE_RX = 2'b10;
  localparam logic [1:0] MODE_TX = 2'b11;

  typedef enum logic [2:0] {
    ENG_IDLE, ENG_START, ENG_BITS, ENG_HOLD, ENG_STOP
  } eng_st_t;

  // {scl pulled low, sda pulled low} for an engine position
  function automatic logic [1:0] line_drive(eng_st_t st, logic [1:0] q,
                                            logic [3:0] bitn, logic txm,
                                            logic msb, logic ack_drv);
    logic [1:0] d;
    case (st)
      ENG_START: d = {q == 2'd2, q != 2'd0};
      ENG_BITS:  d = {q < 2'd2, (bitn < 4'd8) ? (txm & ~msb) : (~txm & ack_drv)};
      ENG_HOLD:  d = 2'b10;
      ENG_STOP:  d = {q == 2'd0, q != 2'd2};
      default:   d = 2'b00;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/i2cm_qtick.sv
module i2cm_qtick #(
  parameter int QTR_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/i2cm_bit_engine.sv
module i2cm_bit_engine
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       go_start,
  input  logic       go_byte,
  input  logic       go_stop,
  input  logic       abort,
  input  logic       tx_mode,
  input  logic [7:0] tx_data,
  input  logic       ack_drive,
  input  logic       sda_in,
  output logic       scl_low,
  output logic       sda_low,
  output logic       idle,
  output logic       held,
  output logic       done,
  output logic       ack_bit,
  output logic [7:0] rx_byte
);
  eng_st_t    st, st_n;
  logic [1:0] q, q_n;
  logic [3:0] bitn, bit_n;
  logic [7:0] sh, sh_n;
  logic       txm, txm_n, ack_s, ack_n, done_n;

  always_comb begin
    st_n = st; q_n = q; bit_n = bitn; sh_n = sh;
    txm_n = txm; ack_n = ack_s; done_n = 1'b0;
    if (abort) begin
      st_n = ENG_IDLE;
    end else begin
      case (st)
        ENG_IDLE: if (go_start) begin
          st_n = ENG_START; q_n = '0; bit_n = '0; sh_n = tx_data; txm_n = 1'b1;
        end
        ENG_START: if (tick) begin
          if (q == 2'd2) begin st_n = ENG_BITS; q_n = '0; end
          else q_n = q + 2'd1;
        end
        ENG_BITS: if (tick) begin
          if (q == 2'd2) begin
            if (bitn == 4'd8) ack_n = sda_in;
            else if (!txm) sh_n = {sh[6:0], sda_in};
          end
          if (q == 2'd3) begin
            q_n = '0;
            if (bitn == 4'd8) begin st_n = ENG_HOLD; done_n = 1'b1; end
            else begin
              bit_n = bitn + 4'd1;
              if (txm) sh_n = {sh[6:0], 1'b0};
            end
          end else q_n = q + 2'd1;
        end
        ENG_HOLD: if (go_byte) begin
          st_n = ENG_BITS; q_n = '0; bit_n = '0; sh_n = tx_data; txm_n = tx_mode;
        end else if (go_stop) begin
          st_n = ENG_STOP; q_n = '0;
        end
        ENG_STOP: if (tick) begin
          if (q == 2'd2) st_n = ENG_IDLE;
          else q_n = q + 2'd1;
        end
        default: st_n = ENG_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ENG_IDLE; q <= '0; bitn <= '0; sh <= '0; txm <= 1'b0;
      ack_s <= 1'b0; done <= 1'b0; scl_low <= 1'b0; sda_low <= 1'b0;
    end else begin
      st <= st_n; q <= q_n; bitn <= bit_n; sh <= sh_n; txm <= txm_n;
      ack_s <= ack_n; done <= done_n;
      {scl_low, sda_low} <= line_drive(st_n, q_n, bit_n, txm_n, sh_n[7], ack_drive);
    end
  end

  assign idle    = (st == ENG_IDLE);
  assign held    = (st == ENG_HOLD);
  assign ack_bit = ack_s;
  assign rx_byte = sh;

  // R11
  sda_hi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ENG_BITS && $past(st == ENG_BITS) && !scl_low && !$past(scl_low))
      |-> $stable(sda_low));
  // R11
  stall_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> scl_low);
  // R5
  cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go_start, go_byte, go_stop}));
endmodule

// File: rtl/i2c_mstr_ctrl.sv
module i2c_mstr_ctrl
  import i2cm_pkg::*;
#(
  parameter int QTR_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq,
  output logic              scl_low,
  output logic              sda_low,
  input  logic              sda_in
);
  logic       ack_en, ien, pend;
  logic [1:0] ctrl_lo;
  logic       ctrl_b6;
  logic [1:0] mode;
  logic       busy, oe, lrb;
  logic [2:0] stat_mid;
  logic [7:0] own, dsr, lctl;
  logic       addr_phase;

  logic tick, eng_idle, eng_held, eng_done, eng_ack;
  logic [7:0] eng_rx;

  logic wr_ctrl, wr_stat, wr_own, wr_data, wr_line;
  logic pend_clr, go_start, go_byte, go_stop, abort;

  assign wr_ctrl = reg_we && reg_addr == OFS_CTRL;
  assign wr_stat = reg_we && reg_addr == OFS_STAT;
  assign wr_own  = reg_we && reg_addr == OFS_OWN;
  assign wr_data = reg_we && reg_addr == OFS_DATA;
  assign wr_line = reg_we && reg_addr == OFS_LINE;

  assign pend_clr = wr_ctrl && pend && !reg_wdata[4];
  assign go_byte  = pend_clr && reg_wdata[5] && busy && eng_held;
  assign abort    = wr_stat && !reg_wdata[4];
  assign go_start = wr_stat && reg_wdata[4] && reg_wdata[7] && reg_wdata[5] && eng_idle;
  assign go_stop  = wr_stat && reg_wdata[4] && reg_wdata[7] && !reg_wdata[5] && eng_held;

  i2cm_qtick #(.QTR_CYC(QTR_CYC)) u_qtick (.clk(clk), .rst_n(rst_n), .tick(tick));

  i2cm_bit_engine u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .go_start(go_start), .go_byte(go_byte), .go_stop(go_stop), .abort(abort),
    .tx_mode(mode == MODE_TX), .tx_data(dsr), .ack_drive(ack_en), .sda_in(sda_in),
    .scl_low(scl_low), .sda_low(sda_low), .idle(eng_idle), .held(eng_held),
    .done(eng_done), .ack_bit(eng_ack), .rx_byte(eng_rx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_en <= 1'b0; ien <= 1'b0; pend <= 1'b0; ctrl_b6 <= 1'b0; ctrl_lo <= '0;
      mode <= '0; busy <= 1'b0; oe <= 1'b0; lrb <= 1'b0; stat_mid <= '0;
      own <= 8'hFF; dsr <= 8'hFF; lctl <= 8'h00; addr_phase <= 1'b0;
    end else begin
      if (eng_done) begin
        lrb <= eng_ack & ack_en;
        if (ien) pend <= 1'b1;
        if (!addr_phase && mode == MODE_RX) dsr <= eng_rx;
        addr_phase <= 1'b0;
      end
      if (wr_ctrl) begin
        ack_en <= reg_wdata[7]; ctrl_b6 <= reg_wdata[6]; ien <= reg_wdata[5];
        ctrl_lo <= reg_wdata[1:0];
        if (pend_clr) begin
          pend <= 1'b0;
          if (!go_byte) busy <= 1'b0;
        end
      end
      if (wr_stat) begin
        mode <= reg_wdata[7:6]; oe <= reg_wdata[4];
        stat_mid <= reg_wdata[3:1]; lrb <= reg_wdata[0];
        if (!reg_wdata[4]) begin
          busy <= 1'b0; pend <= 1'b0;
        end else if (reg_wdata[7]) begin
          if (reg_wdata[5]) begin
            if (eng_idle) begin busy <= 1'b1; lrb <= 1'b0; addr_phase <= 1'b1; end
          end else if (!pend) busy <= 1'b0;
        end
      end
      if (wr_own && !oe) own <= reg_wdata;
      if (wr_data && oe) dsr <= reg_wdata;
      if (wr_line) lctl <= reg_wdata;
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_CTRL: reg_rdata = {ack_en, ctrl_b6, ien, pend, 2'b00, ctrl_lo};
      OFS_STAT: reg_rdata = {mode, busy, oe, stat_mid, lrb};
      OFS_OWN:  reg_rdata = own;
      OFS_DATA: reg_rdata = dsr;
      OFS_LINE: reg_rdata = lctl;
      default:  reg_rdata = 8'h00;
    endcase
  end

  assign irq = pend;

  // R4
  pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(eng_done));
  // R4
  pend_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && reg_wdata[4] && !pend && !eng_done) |=> !irq);
  // R10
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !irq && !scl_low && !sda_low));
  // R5
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_start |=> (busy && !lrb));
  // R12
  ien_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr && !reg_wdata[5]) |=> !busy);
endmodule

// File: tb/i2c_mstr_ctrl_bench.sv
`timescale 1ns/1ps
module i2c_mstr_ctrl_bench;
  localparam logic [4:0] A_CTL = 5'h00, A_STS = 5'h04, A_OWN = 5'h08,
                         A_DAT = 5'h0C, A_LIN = 5'h10;
  localparam logic [6:0] TGT = 7'h52;

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic irq, scl_low, sda_low;
  logic tgt_low = 1'b0;
  wire scl_line = ~scl_low;
  wire sda_line = ~(sda_low | tgt_low);

  int n_chk = 0, n_fail = 0, cyc = 0;

  i2c_mstr_ctrl u_i2c_mstr_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_low(scl_low), .sda_low(sda_low), .sda_in(sda_line)
  );

  always #2 clk = ~clk;

  // behavioural target on the wired lines
  logic p_scl = 1'b1, p_sda = 1'b1;
  logic active = 0, in_addr = 0, rd_mode = 0, m_ack = 0;
  int bitc = 0, starts = 0, stops = 0, wr_cnt = 0, rd_cnt = 0;
  logic [7:0] sh = '0, wr_log = '0, rd_byte = '0;

  always @(scl_line, sda_line) begin
    if (scl_line && p_scl && p_sda && !sda_line) begin
      active = 1; bitc = 0; in_addr = 1; rd_mode = 0; tgt_low = 0; starts++;
    end else if (scl_line && p_scl && !p_sda && sda_line) begin
      active = 0; tgt_low = 0; stops++;
    end else if (active && scl_line && !p_scl) begin
      if (bitc < 8) sh = {sh[6:0], sda_line};
      else if (rd_mode && !in_addr) m_ack = !sda_line;
      bitc++;
    end else if (active && !scl_line && p_scl) begin
      if (bitc == 8) begin
        if (in_addr) begin
          rd_mode = (sh[7:1] == TGT) && sh[0];
          tgt_low = (sh[7:1] == TGT);
          if (sh[7:1] != TGT) active = 0;
        end else if (rd_mode) tgt_low = 0;
        else begin wr_log = sh; wr_cnt++; tgt_low = 1; end
      end else if (bitc == 9) begin
        bitc = 0;
        if (in_addr) begin
          in_addr = 0;
          if (rd_mode) begin rd_byte = 8'h3A + 8'h11 * 8'(rd_cnt); tgt_low = !rd_byte[7]; end
          else tgt_low = 0;
        end else if (rd_mode) begin
          rd_cnt++;
          if (m_ack) begin rd_byte = 8'h3A + 8'h11 * 8'(rd_cnt); tgt_low = !rd_byte[7]; end
          else begin rd_mode = 0; tgt_low = 0; end
        end else tgt_low = 0;
      end else if (rd_mode && !in_addr && bitc >= 1 && bitc <= 7) begin
        tgt_low = !rd_byte[7-bitc];
      end
    end
    p_scl = scl_line; p_sda = sda_line;
  end

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] v);
    reg_addr = a; #0.5 v = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_irq(input string req);
    for (int i = 0; i < 2000; i++) begin
      if (irq) break;
      @(negedge clk);
    end
    chk(req, "irq after byte", irq, 1);
  endtask

  task automatic begin_tx(input logic [7:0] ctl, input logic [7:0] adr);
    wr(A_CTL, ctl); wr(A_STS, 8'hD0); wr(A_DAT, adr); wr(A_STS, 8'hF0);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(A_CTL, v); chk("R1", "ctrl", v, 8'h00);
    rd(A_STS, v); chk("R1", "status", v, 8'h00);
    rd(A_OWN, v); chk("R1", "own", v, 8'hFF);
    rd(A_DAT, v); chk("R1", "data", v, 8'hFF);
    rd(A_LIN, v); chk("R1", "line", v, 8'h00);
    chk("R1", "irq/lines", {irq, scl_low, sda_low}, 3'b000);
    rd(5'h14, v); chk("R2", "unmapped", v, 8'h00);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    wr(A_LIN, 8'h3C); rd(A_LIN, v); chk("R2", "line store", v, 8'h3C);
    wr(A_OWN, 8'h5A); rd(A_OWN, v); chk("R3", "own oe=0", v, 8'h5A);
    wr(A_DAT, 8'h11); rd(A_DAT, v); chk("R3", "data oe=0", v, 8'hFF);
    wr(A_CTL, 8'hB0); rd(A_CTL, v); chk("R4", "pend w1", v, 8'hA0);
    chk("R4", "irq", irq, 0);
    wr(A_STS, 8'hD0);
    wr(A_DAT, 8'h11); rd(A_DAT, v); chk("R3", "data oe=1", v, 8'h11);
    wr(A_OWN, 8'h77); rd(A_OWN, v); chk("R3", "own oe=1", v, 8'h5A);
  endtask

  task automatic t_tx;
    logic [7:0] v; int s0, w0, p0;
    s0 = starts; w0 = wr_cnt;
    begin_tx(8'hA0, {TGT, 1'b0});
    rd(A_STS, v); chk("R5", "busy after start", v, 8'hF0);
    wait_irq("R5");
    rd(A_CTL, v); chk("R4", "pend set", v, 8'hB0);
    rd(A_STS, v); chk("R6", "addr acked", v[0], 0);
    chk("R5", "start seen", starts, s0 + 1);
    wr(A_DAT, 8'hC5); idle(60);
    chk("R11", "scl parked", scl_low, 1);
    chk("R11", "no byte while parked", wr_cnt, w0);
    wr(A_CTL, 8'hA0); chk("R4", "irq cleared", irq, 0);
    wait_irq("R7");
    chk("R7", "byte sent", wr_log, 8'hC5);
    chk("R7", "byte count", wr_cnt, w0 + 1);
    p0 = stops;
    wr(A_STS, 8'hD0); rd(A_STS, v); chk("R9", "busy kept while pend", v[5], 1);
    idle(40);
    chk("R9", "stop seen", stops, p0 + 1);
    chk("R9", "lines free", {scl_low, sda_low}, 2'b00);
    wr(A_CTL, 8'hA0); rd(A_STS, v); chk("R9", "busy after clear", v[5], 0);
    idle(200); chk("R9", "no resume", wr_cnt, w0 + 1);
  endtask

  task automatic t_nack;
    logic [7:0] v;
    begin_tx(8'hA0, 8'h60); wait_irq("R6");
    rd(A_STS, v); chk("R6", "nack flagged", v[0], 1);
    wr(A_STS, 8'hD0); idle(40); wr(A_CTL, 8'hA0);
    begin_tx(8'h20, 8'h60); wait_irq("R6");
    rd(A_STS, v); chk("R6", "nack hidden ack_en=0", v[0], 0);
    wr(A_STS, 8'hD0); idle(40); wr(A_CTL, 8'h20);
  endtask

  task automatic t_rx;
    logic [7:0] v; int p0;
    wr(A_CTL, 8'hA0); wr(A_STS, 8'h90); wr(A_DAT, {TGT, 1'b1}); wr(A_STS, 8'hB0);
    wait_irq("R8");
    wr(A_CTL, 8'hA0); wait_irq("R8");
    rd(A_DAT, v); chk("R8", "first rx byte", v, 8'h3A);
    chk("R8", "master ack", m_ack, 1);
    wr(A_CTL, 8'h20); wait_irq("R8");
    rd(A_DAT, v); chk("R8", "second rx byte", v, 8'h4B);
    chk("R8", "master nack", m_ack, 0);
    p0 = stops;
    wr(A_STS, 8'h90); idle(40); chk("R9", "rx stop", stops, p0 + 1);
    wr(A_CTL, 8'h20);
  endtask

  task automatic t_oe;
    logic [7:0] v;
    begin_tx(8'hA0, {TGT, 1'b0}); wait_irq("R10");
    wr(A_STS, 8'h00);
    chk("R10", "irq dropped", irq, 0);
    rd(A_STS, v); chk("R10", "status", v, 8'h00);
    rd(A_CTL, v); chk("R10", "pend cleared", v, 8'hA0);
    chk("R10", "lines free", {scl_low, sda_low}, 2'b00);
  endtask

  task automatic t_ien;
    logic [7:0] v; int w0;
    w0 = wr_cnt;
    begin_tx(8'hA0, {TGT, 1'b0}); wait_irq("R12");
    wr(A_CTL, 8'h80);
    rd(A_STS, v); chk("R12", "busy cleared", v, 8'hD0);
    chk("R12", "irq low", irq, 0);
    idle(200); chk("R12", "no resume", wr_cnt, w0);
    wr(A_STS, 8'h00);
  endtask

  initial begin
    for (;;) begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: got %0d cycles expected < 150000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    idle(3); rst_n = 1; idle(2);
    t_reset; t_regs; t_tx; t_nack; t_rx; t_oe; t_ien;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule